// File: doc/BRIEF.md
# Nine-bit three-wire serial writer

This block sends command and parameter bytes to a display controller over a write-only serial link. The link has three lines: an active-low chip select, a serial clock and a data line. A client offers one byte at a time, together with a flag that says whether the byte is a command or a parameter, through a valid/ready handshake. The block turns each byte into a 9-bit frame. The flag is the leading bit, so the receiver can tell commands from parameters without a separate line.

Once a request is accepted, chip select goes low. After a programmable set-up interval the frame is shifted out, most significant bit first. The serial clock idles high. For every bit the clock drops, the data line takes the new bit, and after a programmable half period the clock rises again; the receiver samples on that rising edge. After the last bit the data line returns high while chip select is still low, and one half period later chip select is released. A one-cycle done pulse marks the release. Every interval is a count of system clock cycles, set by parameters.

Top module: `tw9_writer`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the first cycle after it, chip select, serial clock and data are all high, ready is 1, busy is 0 and done is 0.
- R2: A frame has 9 bits, sent most significant first. The first bit is the flag (0 = command, 1 = parameter), followed by bits 7 down to 0 of the byte.
- R3: Chip select goes low in the cycle after acceptance. It stays low for exactly SETUP_CYC cycles, with the serial clock high, before the first falling edge of the serial clock. The serial clock is never low while chip select is high.
- R4: Each low half and each high half of a bit lasts exactly HALF_CYC system cycles. The data line does not change on a rising edge of the serial clock.
- R5: After the ninth rising edge, the data line is driven high while chip select stays low. Chip select rises exactly 2*HALF_CYC cycles after that ninth rising edge, and data is high when it does.
- R6: A request is accepted only when ready is 1, which happens only while the block is idle. Ready is 0 and busy is 1 from the cycle after acceptance until chip select is released. A request presented while busy has no effect: no frame is produced for it.
- R7: Done is high for exactly one cycle, and that cycle is the first cycle in which chip select is high again after a frame.
- R8: A request offered during the done cycle is accepted at once, so chip select stays high for exactly one cycle between back-to-back frames.
- R9: A reset applied in the middle of a frame forces all three lines high and ready to 1 in the next cycle, with no done pulse. The next request produces a complete, correct frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; accepts a request |
| req_is_param | input | 1 | 1 = parameter byte, 0 = command byte |
| req_byte | input | BYTE_W | Byte to send |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle pulse when chip select is released |
| ser_csn | output | 1 | Chip select, active low |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_dat | output | 1 | Serial data, idles high |

## Verification
Frames are sent with the flag both 0 and 1. The bytes include all zeros, all ones, alternating bits and irregular values, so a swapped flag position, a reversed bit order or a stuck data bit each show up as a wrong captured frame. Every frame is also measured for its set-up length, each half-period length, its tail length and the placement of done. Back-to-back requests check the one-cycle gap. A request held through a busy frame checks that it is ignored. A reset in the middle of a frame checks the abort and the recovery that follows.

// File: rtl/tw9_pkg.sv
package tw9_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_LOW,
      ST_HIGH,
      ST_TAIL
   } tw9_state_e;

   function automatic int tw9_cnt_width(input int a, input int b);
      int m;
      m = (a > b) ? a : b;
      return (m < 2) ? 1 : $clog2(m);
   endfunction

endpackage

// File: rtl/tw9_timer.sv
module tw9_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // R4: every half period counts down one step per cycle, with no wrap.
   a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
      (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/tw9_shifter.sv
module tw9_shifter #(
   parameter int FRAME_W = 9
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic               shift,
   output logic               msb,
   output logic               last
);

   localparam int IDX_W = (FRAME_W < 2) ? 1 : $clog2(FRAME_W);

   logic [FRAME_W-1:0] sh_q;
   logic [IDX_W-1:0]   idx_q;

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("tw9_shifter: FRAME_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q  <= '1;
         idx_q <= '0;
      end else if (load) begin
         sh_q  <= frame_in;
         idx_q <= '0;
      end else if (shift) begin
         sh_q  <= {sh_q[FRAME_W-2:0], 1'b1};
         idx_q <= idx_q + 1'b1;
      end
   end

   assign msb  = sh_q[FRAME_W-1];
   assign last = (idx_q == IDX_W'(FRAME_W - 1));

   // R2: the controller never shifts beyond the final bit of a frame.
   a_r2_no_overshift: assert property (@(posedge clk) disable iff (rst)
      shift |-> !last);

   // R2: loading and shifting are exclusive.
   a_r2_load_xor_shift: assert property (@(posedge clk) disable iff (rst)
      !(load && shift));

endmodule

// File: rtl/tw9_writer.sv
module tw9_writer
   import tw9_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int SETUP_CYC = 4,
   parameter int HALF_CYC  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_is_param,
   input  logic [BYTE_W-1:0] req_byte,
   output logic              busy,
   output logic              done,
   output logic              ser_csn,
   output logic              ser_clk,
   output logic              ser_dat
);

   localparam int FRAME_W = BYTE_W + 1;
   localparam int CNT_W   = tw9_cnt_width(SETUP_CYC, HALF_CYC);
   localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_CYC - 1);

   generate
      if (BYTE_W < 1) begin : g_bad_byte
         $error("tw9_writer: BYTE_W must be at least 1");
      end
      if (SETUP_CYC < 1) begin : g_bad_setup
         $error("tw9_writer: SETUP_CYC must be at least 1");
      end
      if (HALF_CYC < 1) begin : g_bad_half
         $error("tw9_writer: HALF_CYC must be at least 1");
      end
   endgenerate

   tw9_state_e       state_q, state_nx;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_exp;
   logic             sh_load, sh_shift, sh_msb, sh_last;
   logic             accept;
   logic             done_q;

   assign accept = req_valid && req_ready;

   always_comb begin
      state_nx = state_q;
      tmr_load = 1'b0;
      tmr_val  = HALF_LD;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               state_nx = ST_SETUP;
               tmr_load = 1'b1;
               tmr_val  = SETUP_LD;
               sh_load  = 1'b1;
            end
         end
         ST_SETUP: begin
            if (tmr_exp) begin
               state_nx = ST_LOW;
               tmr_load = 1'b1;
            end
         end
         ST_LOW: begin
            if (tmr_exp) begin
               state_nx = ST_HIGH;
               tmr_load = 1'b1;
            end
         end
         ST_HIGH: begin
            if (tmr_exp) begin
               tmr_load = 1'b1;
               if (sh_last) begin
                  state_nx = ST_TAIL;
               end else begin
                  state_nx = ST_LOW;
                  sh_shift = 1'b1;
               end
            end
         end
         ST_TAIL: begin
            if (tmr_exp)
               state_nx = ST_IDLE;
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_nx;
         done_q  <= (state_q == ST_TAIL) && tmr_exp;
      end
   end

   tw9_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   tw9_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .load     (sh_load),
      .frame_in ({req_is_param, req_byte}),
      .shift    (sh_shift),
      .msb      (sh_msb),
      .last     (sh_last)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign busy      = !req_ready;
   assign done      = done_q;
   assign ser_csn   = (state_q == ST_IDLE);
   assign ser_clk   = (state_q != ST_LOW);
   assign ser_dat   = (state_q == ST_LOW || state_q == ST_HIGH) ? sh_msb : 1'b1;

   // R3: the serial clock is low only inside an active frame.
   a_r3_clk_inside_frame: assert property (@(posedge clk) disable iff (rst)
      !ser_clk |-> !ser_csn);

   // R4: data holds across each rising edge of the serial clock.
   a_r4_dat_stable_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(ser_clk) |-> $stable(ser_dat));

   // R6: acceptance leads to chip select low in the next cycle.
   a_r6_accept_starts: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> !ser_csn);

   // R6: ready only while the link is released.
   a_r6_ready_idle: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> ser_csn);

   // R7: each release of chip select comes with done.
   a_r7_done_on_release: assert property (@(posedge clk) disable iff (rst)
      $rose(ser_csn) |-> done);

   // R7: done lasts a single cycle.
   a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R5: data is high when chip select is released.
   a_r5_dat_high_release: assert property (@(posedge clk) disable iff (rst)
      $rose(ser_csn) |-> ser_dat);

endmodule

// File: tb/sim_tw9_writer.sv
module sim_tw9_writer;

   localparam int SETUP = 3;
   localparam int HALF  = 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req_valid = 1'b0;
   logic       req_is_param = 1'b0;
   logic [7:0] req_byte = '0;
   logic       req_ready, busy, done, ser_csn, ser_clk, ser_dat;

   int n_cmp = 0;
   int n_bad = 0;
   logic [8:0] exp_q[$];

   always #2 clk = ~clk;

   tw9_writer #(.BYTE_W(8), .SETUP_CYC(SETUP), .HALF_CYC(HALF)) u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_is_param(req_is_param), .req_byte(req_byte), .busy(busy),
      .done(done), .ser_csn(ser_csn), .ser_clk(ser_clk), .ser_dat(ser_dat)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, expv, $time);
      end
   endtask

   // monitor state
   logic pcsn = 1'b1, psck = 1'b1, pdat = 1'b1, pdone = 1'b0;
   bit   in_frame = 0, seen_fall = 0;
   int   setup_cnt, run_lo, run_hi, nbits, csn_hi_run, last_gap;
   logic [8:0] frm;

   always @(negedge clk) begin
      if (rst) begin
         in_frame = 0; pcsn = 1'b1; psck = 1'b1; pdat = 1'b1; pdone = 1'b0;
         csn_hi_run = 0;
      end else begin
         if (pcsn && !ser_csn) begin
            last_gap = csn_hi_run;
            in_frame = 1; seen_fall = 0; setup_cnt = 1;
            nbits = 0; frm = '0; run_lo = 0; run_hi = 0;
         end else if (in_frame && !ser_csn) begin
            if (!seen_fall) begin
               if (ser_clk) setup_cnt++;
               else begin
                  chk(setup_cnt == SETUP, "R3 setup length", setup_cnt, SETUP);
                  chk(!req_ready && busy, "R6 ready/busy in frame",
                      {req_ready, busy}, 2'b01);
                  seen_fall = 1; run_lo = 1;
               end
            end else if (psck && !ser_clk) begin
               chk(run_hi == HALF, "R4 high half", run_hi, HALF);
               run_lo = 1;
            end else if (!psck && ser_clk) begin
               chk(run_lo == HALF, "R4 low half", run_lo, HALF);
               frm = {frm[7:0], ser_dat};
               nbits++;
               run_hi = 1;
            end else if (ser_clk) run_hi++;
            else run_lo++;
         end else if (in_frame && ser_csn) begin
            chk(pdat == 1'b1, "R5 data high before release", pdat, 1);
            chk(run_hi == 2*HALF, "R5 tail length", run_hi, 2*HALF);
            chk(nbits == 9, "R2 bit count", nbits, 9);
            if (exp_q.size() == 0)
               chk(0, "R2 unexpected frame", frm, 0);
            else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               chk(frm == e, "R2 frame content", frm, e);
            end
            chk(done == 1'b1, "R7 done at release", done, 1);
            in_frame = 0; csn_hi_run = 1;
         end else if (ser_csn) csn_hi_run++;
         if (done && pdone) chk(0, "R7 done width", 2, 1);
         pcsn = ser_csn; psck = ser_clk; pdat = ser_dat; pdone = done;
      end
   end

   task automatic send(input logic p, input logic [7:0] b);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_is_param = p; req_byte = b;
      exp_q.push_back({p, b});
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (in_frame || exp_q.size() != 0 || !ser_csn) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: lines idle high during reset
      chk({ser_csn, ser_clk, ser_dat} == 3'b111, "R1 lines in reset",
          {ser_csn, ser_clk, ser_dat}, 3'b111);
      rst = 1'b0;
      @(negedge clk);
      chk(req_ready && !busy && !done, "R1 handshake after reset",
          {req_ready, busy, done}, 3'b100);

      // R2: command and parameter frames, varied byte patterns
      send(1'b0, 8'hB9); wait_idle();
      send(1'b1, 8'h00); wait_idle();
      send(1'b0, 8'hFF); wait_idle();
      send(1'b1, 8'hAA); wait_idle();
      send(1'b0, 8'h55); wait_idle();
      send(1'b1, 8'h83); wait_idle();

      // R8: back-to-back frames, one-cycle gap
      send(1'b0, 8'h3A);
      send(1'b1, 8'h66);
      @(negedge clk);
      while (!in_frame) @(negedge clk);
      chk(last_gap == 1, "R8 gap between frames", last_gap, 1);
      wait_idle();

      // R6: request held while busy is ignored
      send(1'b1, 8'h3C);
      req_valid = 1'b1; req_is_param = 1'b0; req_byte = 8'hE7;
      repeat (20) @(negedge clk);
      req_valid = 1'b0;
      wait_idle();
      repeat (10) @(negedge clk);
      chk(ser_csn == 1'b1 && !in_frame, "R6 ignored request made no frame",
          ser_csn, 1);

      // R9: reset in mid frame
      send(1'b0, 8'hA5);
      repeat (15) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk({ser_csn, ser_clk, ser_dat, req_ready, done} == 5'b11110,
          "R9 abort state", {ser_csn, ser_clk, ser_dat, req_ready, done}, 5'b11110);
      @(negedge clk);
      exp_q.delete();
      rst = 1'b0;
      send(1'b1, 8'h29); wait_idle();
      chk(exp_q.size() == 0, "R9 recovery frame consumed", exp_q.size(), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule